// File: doc/BRIEF.md
# Debug System-Speed Access Sequencer

This block orders memory accesses that a debugger asks for while the core is halted. The debugger shifts instruction words in through a scan chain. Each word carries one extra speed flag. A word with the flag low is taken at debug speed and becomes the current candidate; the block puts nothing on the bus for it. A no-op word with the flag high that follows a load/store candidate arms that candidate for system-speed execution.

An armed access waits until the TAP holds the restart instruction and sits in its idle state. The block then passes a start request into the system-clock side and runs the access there. Each transfer beat is held for as long as the active-low memory wait line asks. When the last beat ends, a done indication comes back to the debug side. The block raises the debug acknowledge and sets the completion bit of its status word; that bit is the only sign that the access has ended.

Both clock domains are modelled on one clock, with state enables in place of a clock multiplexer. Each crossing goes through a multi-stage synchroniser on a toggle signal, so a request can be neither lost nor repeated.

Top module: `dbg_sysacc_ctrl`

## Requirements
- R1: After reset, dbg_ack is 1, every bit of dbg_status is 0 and mem_req is 0.
- R2: The instruction word has three fields: op at bits 31:29, beat count at bits 19:16 and address at bits 15:0. The op codes are 0 no-op, 1 load, 2 store, 3 load-multiple, 4 store-multiple; 5 to 7 are not transfers. A scanned word with scan_sysspd low becomes the candidate. It causes no bus request and does not arm.
- R3: A scanned no-op word with scan_sysspd high, after a candidate with op 1 to 4, arms that candidate. It sets dbg_status bit 0, clears bit 3 (completion) and bit 4 (reject), and drives dbg_ack low. dbg_ack stays low until the access completes.
- R4: A flagged word that is not a no-op, or a flagged no-op whose candidate is not op 1 to 4, sets dbg_status bit 4. It does not arm and never reaches the bus.
- R5: An armed access starts only when tap_ir equals the restart code and tap_state equals the idle code in the same cycle. mem_req rises on the fourth clock edge after that cycle is sampled. dbg_status bit 1 is high while the access runs.
- R6: While mem_req is high and mem_wait_n is low, the beat is held with mem_addr and mem_we unchanged. A beat completes on an edge where mem_req and mem_wait_n are both high.
- R7: Ops 3 and 4 issue count+1 beats back to back, at consecutive addresses that wrap modulo 2^ADDR_W. Ops 1 and 2 issue one beat.
- R8: Loads drive mem_we low, and rd_data takes mem_rdata of each completed beat, so it ends with the last beat's data. Stores drive mem_we high with mem_wdata equal to dbg_wdata.
- R9: Completion bit 3 and dbg_ack rise on the third edge after the last beat completes. At that point bits 0 and 1 are low.
- R10: Scanned words are ignored while an access runs. They neither arm, reject nor replace the candidate.
- R11: Each arming gives exactly one bus sequence. Holding the restart code and idle state after completion issues no further beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both modelled domains |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_valid | input | 1 | A scanned word is presented this cycle |
| scan_word | input | 32 | Scanned instruction word |
| scan_sysspd | input | 1 | Speed flag scanned with the word |
| dbg_wdata | input | DATA_W | Store data supplied by the debugger |
| tap_state | input | 4 | Current TAP controller state code |
| tap_ir | input | IR_W | Current TAP instruction code |
| mem_req | output | 1 | Bus beat requested |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data returned by the bus |
| mem_wait_n | input | 1 | Active-low stall of the current beat |
| rd_data | output | DATA_W | Latched load data readable by the debugger |
| dbg_ack | output | 1 | Debug acknowledge, high when halted and idle |
| dbg_status | output | STAT_W | Status: bit 0 armed, bit 1 running, bit 3 complete, bit 4 rejected |

## Verification
The arming result appears on the edge that captures the flagged no-op, so it is read at the next falling edge. The bus request appears four edges after the restart and idle condition is first sampled. The bench reads mem_req as low after three falling edges and as high after the fourth. The bench memory records the edge number of each accepted beat, and the acknowledge must appear exactly four counts after the last one: three synchroniser and handover edges plus the counter offset. All sampling is done on falling edges, away from the edges that move the design.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

   localparam int INSTR_W = 32;
   localparam int OP_LSB  = 29;
   localparam int CNT_LSB = 16;
   localparam int CNT_W   = 4;
   localparam int FLD_AW  = 16;

   localparam logic [2:0] OPC_NOP = 3'd0;
   localparam logic [2:0] OPC_LD  = 3'd1;
   localparam logic [2:0] OPC_ST  = 3'd2;
   localparam logic [2:0] OPC_LDM = 3'd3;
   localparam logic [2:0] OPC_STM = 3'd4;

   localparam int ST_ARMED = 0;
   localparam int ST_RUN   = 1;
   localparam int ST_DONE  = 3;
   localparam int ST_REJ   = 4;

   typedef struct packed {
      logic [2:0]        op;
      logic [CNT_W-1:0]  cnt;
      logic [FLD_AW-1:0] addr;
   } job_t;

   typedef enum logic [1:0] {D_IDLE, D_ARMED, D_RUN} dstate_e;
   typedef enum logic {S_IDLE, S_BEAT} sstate_e;

   function automatic logic is_xfer(input logic [2:0] op);
      return (op == OPC_LD) || (op == OPC_ST) || (op == OPC_LDM) || (op == OPC_STM);
   endfunction

   function automatic logic is_load(input logic [2:0] op);
      return (op == OPC_LD) || (op == OPC_LDM);
   endfunction

   function automatic logic is_multi(input logic [2:0] op);
      return (op == OPC_LDM) || (op == OPC_STM);
   endfunction

   function automatic job_t unpack_word(input logic [INSTR_W-1:0] w);
      job_t j;
      j.op   = w[OP_LSB +: 3];
      j.cnt  = w[CNT_LSB +: CNT_W];
      j.addr = w[FLD_AW-1:0];
      return j;
   endfunction

endpackage

// File: rtl/dsa_sync.sv
module dsa_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dsa_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dsa_dbg_ctrl.sv
module dsa_dbg_ctrl
   import dsa_pkg::*;
#(
   parameter int               IR_W       = 4,
   parameter logic [IR_W-1:0]  RESTART_IR = 4'b0100,
   parameter logic [3:0]       TAP_IDLE   = 4'hC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scan_valid,
   input  logic [INSTR_W-1:0] scan_word,
   input  logic               scan_sysspd,
   input  logic [3:0]         tap_state,
   input  logic [IR_W-1:0]    tap_ir,
   input  logic               done_sync,
   output logic               start_tog,
   output job_t               job,
   output logic               armed,
   output logic               running,
   output logic               done_bit,
   output logic               rej_bit,
   output logic               ack
);

   dstate_e state;
   job_t    cand;
   logic    cand_ok;
   logic    done_seen;
   job_t    scan_job;
   logic    go, done_evt, scan_ok, flag_arm, flag_bad;
   logic    unused_fields;

   assign scan_job      = unpack_word(scan_word);
   assign unused_fields = ^scan_word[OP_LSB-1:CNT_LSB+CNT_W];

   assign go       = (state == D_ARMED) && (tap_ir == RESTART_IR) && (tap_state == TAP_IDLE);
   assign done_evt = (state == D_RUN) && (done_sync != done_seen);
   assign scan_ok  = scan_valid && (state != D_RUN) && !go;
   assign flag_arm = scan_ok && scan_sysspd && (scan_job.op == OPC_NOP) && cand_ok;
   assign flag_bad = scan_ok && scan_sysspd && !((scan_job.op == OPC_NOP) && cand_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= D_IDLE;
         cand      <= '0;
         cand_ok   <= 1'b0;
         job       <= '0;
         start_tog <= 1'b0;
         done_seen <= 1'b0;
         done_bit  <= 1'b0;
         rej_bit   <= 1'b0;
         ack       <= 1'b1;
      end else begin
         if (go) begin
            start_tog <= ~start_tog;
            state     <= D_RUN;
         end
         if (done_evt) begin
            done_seen <= done_sync;
            done_bit  <= 1'b1;
            ack       <= 1'b1;
            state     <= D_IDLE;
         end
         if (scan_ok && !scan_sysspd) begin
            cand    <= scan_job;
            cand_ok <= is_xfer(scan_job.op);
         end
         if (flag_arm) begin
            job      <= cand;
            state    <= D_ARMED;
            done_bit <= 1'b0;
            rej_bit  <= 1'b0;
            ack      <= 1'b0;
         end
         if (flag_bad) rej_bit <= 1'b1;
      end
   end

   assign armed   = (state == D_ARMED);
   assign running = (state == D_RUN);

endmodule

// File: rtl/dsa_sys_seq.sv
module dsa_sys_seq
   import dsa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_sync,
   input  job_t              job,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_wait_n,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              done_tog
);

   sstate_e          state;
   logic             seen;
   logic [CNT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         seen     <= 1'b0;
         left     <= '0;
         mem_addr <= '0;
         mem_we   <= 1'b0;
         rd_data  <= '0;
         done_tog <= 1'b0;
      end else if (state == S_IDLE) begin
         if (start_sync != seen) begin
            seen     <= start_sync;
            state    <= S_BEAT;
            mem_addr <= job.addr[ADDR_W-1:0];
            left     <= is_multi(job.op) ? job.cnt : '0;
            mem_we   <= !is_load(job.op);
         end
      end else if (mem_wait_n) begin
         if (!mem_we) rd_data <= mem_rdata;
         if (left == '0) begin
            state    <= S_IDLE;
            done_tog <= ~done_tog;
         end else begin
            left     <= left - 1'b1;
            mem_addr <= mem_addr + 1'b1;
         end
      end
   end

   assign mem_req   = (state == S_BEAT);
   assign mem_wdata = wdata_in;

endmodule

// File: rtl/dbg_sysacc_ctrl.sv
module dbg_sysacc_ctrl
   import dsa_pkg::*;
#(
   parameter int              ADDR_W      = 16,
   parameter int              DATA_W      = 32,
   parameter int              IR_W        = 4,
   parameter logic [IR_W-1:0] RESTART_IR  = 4'b0100,
   parameter logic [3:0]      TAP_IDLE    = 4'hC,
   parameter int              SYNC_STAGES = 2,
   parameter int              STAT_W      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scan_valid,
   input  logic [INSTR_W-1:0] scan_word,
   input  logic               scan_sysspd,
   input  logic [DATA_W-1:0]  dbg_wdata,
   input  logic [3:0]         tap_state,
   input  logic [IR_W-1:0]    tap_ir,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               mem_wait_n,
   output logic [DATA_W-1:0]  rd_data,
   output logic               dbg_ack,
   output logic [STAT_W-1:0]  dbg_status
);

   generate
      if (ADDR_W < 1 || ADDR_W > FLD_AW) begin : g_bad_addr
         $error("dbg_sysacc_ctrl: ADDR_W must lie in 1..16");
      end
      if (STAT_W <= ST_REJ) begin : g_bad_stat
         $error("dbg_sysacc_ctrl: STAT_W too small for status bits");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dbg_sysacc_ctrl: DATA_W must be positive");
      end
   endgenerate

   logic start_tog, start_sync, done_tog, done_sync;
   logic armed, running, done_bit, rej_bit;
   job_t job;

   dsa_dbg_ctrl #(
      .IR_W       (IR_W),
      .RESTART_IR (RESTART_IR),
      .TAP_IDLE   (TAP_IDLE)
   ) u_dbg (
      .clk         (clk),
      .rst_n       (rst_n),
      .scan_valid  (scan_valid),
      .scan_word   (scan_word),
      .scan_sysspd (scan_sysspd),
      .tap_state   (tap_state),
      .tap_ir      (tap_ir),
      .done_sync   (done_sync),
      .start_tog   (start_tog),
      .job         (job),
      .armed       (armed),
      .running     (running),
      .done_bit    (done_bit),
      .rej_bit     (rej_bit),
      .ack         (dbg_ack)
   );

   dsa_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
      .clk (clk), .rst_n (rst_n), .d (start_tog), .q (start_sync)
   );

   dsa_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
      .clk (clk), .rst_n (rst_n), .d (done_tog), .q (done_sync)
   );

   dsa_sys_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_sys (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_sync (start_sync),
      .job        (job),
      .wdata_in   (dbg_wdata),
      .mem_rdata  (mem_rdata),
      .mem_wait_n (mem_wait_n),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .rd_data    (rd_data),
      .done_tog   (done_tog)
   );

   always_comb begin
      dbg_status           = '0;
      dbg_status[ST_ARMED] = armed;
      dbg_status[ST_RUN]   = running;
      dbg_status[ST_DONE]  = done_bit;
      dbg_status[ST_REJ]   = rej_bit;
   end

endmodule

// File: rtl/dsa_chk.sv
module dsa_chk #(
   parameter int ADDR_W = 16,
   parameter int STAT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_wait_n,
   input logic              dbg_ack,
   input logic [STAT_W-1:0] dbg_status
);

   AST_REQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> dbg_status[1]); // R5

   AST_STALL_HOLDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_wait_n) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R6

   AST_ARM_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_status[0]) |-> (!dbg_status[3] && !dbg_ack && !dbg_status[4])); // R3

   AST_ACK_LOW_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_status[1] |-> !dbg_ack); // R3

   AST_ACK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_ack) |-> (dbg_status[3] && !dbg_status[1] && !dbg_status[0])); // R9

   AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dbg_status[1:0])); // R5

   AST_REJECT_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_status[4]) |-> !$rose(dbg_status[0])); // R4

endmodule

bind dbg_sysacc_ctrl dsa_chk #(
   .ADDR_W (ADDR_W),
   .STAT_W (STAT_W)
) u_dsa_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wait_n (mem_wait_n),
   .dbg_ack    (dbg_ack),
   .dbg_status (dbg_status)
);

// File: tb/dbg_sysacc_ctrl_test.sv
`timescale 1ns/1ps
module dbg_sysacc_ctrl_test;

   localparam logic [3:0] RESTART = 4'b0100;
   localparam logic [3:0] IR_OTH  = 4'h1;
   localparam logic [3:0] T_IDLE  = 4'hC;
   localparam logic [3:0] T_OTH   = 4'h1;

   typedef struct packed {
      logic [2:0]  op;
      logic [3:0]  cnt;
      logic [15:0] addr;
      logic [3:0]  stall;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{3'd1, 4'd0, 16'h0100, 4'd0},
      '{3'd2, 4'd0, 16'h0200, 4'd2},
      '{3'd3, 4'd3, 16'h0300, 4'd1},
      '{3'd4, 4'd2, 16'hFFFE, 4'd0},
      '{3'd1, 4'd5, 16'h0410, 4'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_valid = 1'b0;
   logic [31:0] scan_word = '0;
   logic        scan_sysspd = 1'b0;
   logic [31:0] dbg_wdata = '0;
   logic [3:0]  tap_state = T_OTH;
   logic [3:0]  tap_ir = IR_OTH;
   logic        mem_req, mem_we, mem_wait_n, dbg_ack;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata, rd_data;
   logic [7:0]  dbg_status;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int nbeat = 0;
   int last_acc = 0;
   int stall_ctr = 0;
   int stall_cfg = 0;
   logic [15:0] log_addr [64];
   logic        log_we   [64];
   logic [31:0] log_wd   [64];

   always #2.5 clk = ~clk;

   dbg_sysacc_ctrl uut (
      .clk (clk), .rst_n (rst_n), .scan_valid (scan_valid), .scan_word (scan_word),
      .scan_sysspd (scan_sysspd), .dbg_wdata (dbg_wdata), .tap_state (tap_state),
      .tap_ir (tap_ir), .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_wait_n (mem_wait_n),
      .rd_data (rd_data), .dbg_ack (dbg_ack), .dbg_status (dbg_status)
   );

   function automatic logic [31:0] mem_fn(input logic [15:0] a);
      return {~a, a ^ 16'h5A5A};
   endfunction

   assign mem_rdata  = mem_fn(mem_addr);
   assign mem_wait_n = (stall_ctr == 0);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req) begin
         if (stall_ctr == 0) begin
            log_addr[nbeat % 64] <= mem_addr;
            log_we[nbeat % 64]   <= mem_we;
            log_wd[nbeat % 64]   <= mem_wdata;
            nbeat    <= nbeat + 1;
            last_acc <= cyc;
            stall_ctr <= stall_cfg;
         end else begin
            stall_ctr <= stall_ctr - 1;
         end
      end else begin
         stall_ctr <= stall_cfg;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mkword(input logic [2:0] op, input logic [3:0] cnt,
                                          input logic [15:0] a);
      return {op, 9'd0, cnt, a};
   endfunction

   task automatic scan(input logic [31:0] w, input logic f);
      @(negedge clk);
      scan_valid = 1'b1; scan_word = w; scan_sysspd = f;
      @(negedge clk);
      scan_valid = 1'b0; scan_sysspd = 1'b0;
   endtask

   task automatic wait_ack(input string req);
      int t;
      t = 0;
      while (!dbg_ack && t < 400) begin
         @(negedge clk);
         t++;
      end
      chk({req, " ack within timeout"}, {31'd0, dbg_ack}, 32'd1);
   endtask

   task automatic run_vec(input vec_t v, input logic [31:0] wd);
      int base, beats;
      logic [15:0] ea;
      dbg_wdata = wd; stall_cfg = int'(v.stall); base = nbeat;
      beats = (v.op == 3'd3 || v.op == 3'd4) ? int'(v.cnt) + 1 : 1;
      scan(mkword(v.op, v.cnt, v.addr), 1'b0);
      scan(mkword(3'd0, 4'd0, 16'd0), 1'b1);
      chk("R3 armed bit", {31'd0, dbg_status[0]}, 32'd1);
      chk("R3 ack low", {31'd0, dbg_ack}, 32'd0);
      chk("R3 done and reject cleared", {30'd0, dbg_status[4], dbg_status[3]}, 32'd0);
      tap_ir = RESTART; tap_state = T_OTH;
      repeat (4) @(negedge clk);
      chk("R5 no start without idle", {31'd0, mem_req}, 32'd0);
      tap_state = T_IDLE;
      repeat (3) @(negedge clk);
      chk("R5 req not before fourth edge", {31'd0, mem_req}, 32'd0);
      @(negedge clk);
      chk("R5 req on fourth edge", {31'd0, mem_req}, 32'd1);
      chk("R5 running bit", {31'd0, dbg_status[1]}, 32'd1);
      wait_ack("R9");
      chk("R9 ack three edges after last beat", cyc - last_acc, 32'd4);
      chk("R9 status done only", {24'd0, dbg_status}, 32'h08);
      chk("R7 beat count", nbeat - base, beats);
      for (int j = 0; j < beats; j++) begin
         ea = v.addr + 16'(j);
         chk("R7 beat address", {16'd0, log_addr[(base + j) % 64]}, {16'd0, ea});
         chk("R8 write enable", {31'd0, log_we[(base + j) % 64]},
             (v.op == 3'd2 || v.op == 3'd4) ? 32'd1 : 32'd0);
         if (v.op == 3'd2 || v.op == 3'd4)
            chk("R8 store data", log_wd[(base + j) % 64], wd);
      end
      if (v.op == 3'd1 || v.op == 3'd3) begin
         ea = v.addr + 16'(beats - 1);
         chk("R8 load data of last beat", rd_data, mem_fn(ea));
      end
      repeat (8) @(negedge clk);
      chk("R11 no repeat while restart held", nbeat - base, beats);
      tap_ir = IR_OTH; tap_state = T_OTH;
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk("R1 ack after reset", {31'd0, dbg_ack}, 32'd1);
      chk("R1 req after reset", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after reset", {24'd0, dbg_status}, 32'd0);

      // R2: unflagged word only becomes the candidate
      base = nbeat;
      tap_ir = RESTART; tap_state = T_IDLE;
      scan(mkword(3'd1, 4'd0, 16'h0050), 1'b0);
      repeat (6) @(negedge clk);
      chk("R2 no request for unflagged word", nbeat - base, 32'd0);
      chk("R2 not armed", {24'd0, dbg_status}, 32'd0);
      tap_ir = IR_OTH; tap_state = T_OTH;

      // R4: flagged non-no-op word is rejected
      scan(mkword(3'd1, 4'd0, 16'h0050), 1'b1);
      chk("R4 flagged non-nop rejected", {24'd0, dbg_status}, 32'h10);

      for (int i = 0; i < NV; i++)
         run_vec(VECS[i], 32'hC0DE_0000 + 32'(i));

      // R4: flagged no-op after a non-transfer candidate
      base = nbeat;
      scan(mkword(3'd5, 4'd0, 16'h0070), 1'b0);
      scan(mkword(3'd0, 4'd0, 16'd0), 1'b1);
      chk("R4 non-transfer candidate rejected", {24'd0, dbg_status}, 32'h18);
      tap_ir = RESTART; tap_state = T_IDLE;
      repeat (10) @(negedge clk);
      chk("R4 rejected access never on bus", nbeat - base, 32'd0);
      tap_ir = IR_OTH; tap_state = T_OTH;

      // R10: scans during a running access are ignored
      base = nbeat; stall_cfg = 12;
      scan(mkword(3'd1, 4'd0, 16'h0040), 1'b0);
      scan(mkword(3'd0, 4'd0, 16'd0), 1'b1);
      tap_ir = RESTART; tap_state = T_IDLE;
      repeat (6) @(negedge clk);
      scan(mkword(3'd6, 4'd0, 16'h0999), 1'b0);
      scan(mkword(3'd0, 4'd0, 16'd0), 1'b1);
      scan(mkword(3'd2, 4'd0, 16'h0888), 1'b1);
      wait_ack("R10");
      tap_ir = IR_OTH; tap_state = T_OTH;
      chk("R10 no reject or re-arm from ignored scans", {24'd0, dbg_status}, 32'h08);
      chk("R10 single beat", nbeat - base, 32'd1);
      scan(mkword(3'd0, 4'd0, 16'd0), 1'b1);
      chk("R10 candidate kept, flagged nop re-arms", {31'd0, dbg_status[0]}, 32'd1);
      tap_ir = RESTART; tap_state = T_IDLE;
      wait_ack("R10");
      tap_ir = IR_OTH; tap_state = T_OTH;
      chk("R10 re-armed access uses old candidate", {16'd0, log_addr[(base + 1) % 64]}, 32'h0040);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

endmodule